// File: doc/BRIEF.md
# Tape Record Framing Parser

This block sits behind a tape demodulator. It receives decoded bytes, each marked by a one-cycle valid, and a strobe that marks each gap period between bursts of data. It cuts that stream into length-prefixed records. The first byte after a gap is read as a record length, and the bytes that follow are passed on as payload. Each payload byte carries its position within the record, first and last markers, and a marker that shows it belongs to a fill-data record.

A record of length five is a command record. Its final payload byte is decoded as a command. One code announces that the next record holds fill data. Another code ends the tape, and after it the parser ignores all input until reset. A gap that arrives in the middle of a record's payload abandons that record and raises a one-cycle truncation flag.

All outputs are registered. A byte accepted on one clock edge appears at the outputs after that same edge, so it is visible for the whole following cycle.

Top module: `tape_rec_parser`

## Requirements
- R1: While `rst_n` is low, `pay_valid`, `pay_first`, `pay_last`, `pay_fill`, `cmd_valid`, `fill_cmd`, `trunc_err`, `fill_pending` and `eof` are all 0. After reset, bytes are ignored until the first `gap_strobe`.
- R2: A length byte L in the range 1..255, taken when not in a record, is followed by exactly L payload bytes. Each payload byte is presented one cycle after it is accepted, with `pay_index` counting 0..L-1. Idle cycles between bytes are allowed.
- R3: A length byte of 0x00 means 256 payload bytes, and the last of them carries `pay_index` 255.
- R4: `pay_first` is 1 only on index 0, and `pay_last` is 1 only on the final payload byte of a record. Both are 1 on a record of length 1.
- R5: In a record whose length byte is 5, the fifth payload byte raises `cmd_valid` for one cycle, and `cmd_code` equals that byte. Records of any other length never raise `cmd_valid`.
- R6: Command code 0xFE pulses `fill_cmd` and sets `fill_pending`. Every payload byte of the next record that starts carries `pay_fill`=1. `fill_pending` clears on the last byte of that record, unless that byte is itself a 0xFE command.
- R7: Command code 0xFD sets `eof`. From then until reset, every input is ignored: no `pay_valid`, no `trunc_err`, and `eof` stays 1.
- R8: A `gap_strobe` during payload ends the record and pulses `trunc_err` one cycle later with `pay_valid` 0. A byte in the same cycle as that gap is dropped. The next byte after the gap is a length byte. `fill_pending` is unchanged, and the next complete record is the fill record.
- R9: A `gap_strobe` while waiting for a length byte has no effect on outputs or on record framing.
- R10: A command code other than 0xFE and 0xFD raises only `cmd_valid`: neither `fill_cmd` nor `eof`, and `fill_pending` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | Decoded byte present this cycle |
| byte_data | input | 8 | Decoded byte |
| gap_strobe | input | 1 | One gap period detected |
| pay_valid | output | 1 | Payload byte presented |
| pay_data | output | 8 | Payload byte |
| pay_index | output | 9 | Position of the byte within its record |
| pay_first | output | 1 | First payload byte of the record |
| pay_last | output | 1 | Last payload byte of the record |
| pay_fill | output | 1 | Byte belongs to a fill-data record |
| cmd_valid | output | 1 | Command byte decoded this cycle |
| cmd_code | output | 8 | Most recent command code |
| fill_cmd | output | 1 | Fill command decoded this cycle |
| trunc_err | output | 1 | Record cut short by a gap |
| fill_pending | output | 1 | Fill record is expected or in progress |
| eof | output | 1 | End of tape reached |

## Verification
The bench goes after the length-zero record. A design that treated zero as zero bytes, or wrapped its counter, would give up after one byte or cut off before index 255. It checks a one-byte record, where a first/last decode keyed on only one end would miss a marker. It sends a gap together with a byte in the middle of a record. A design that let the byte win would emit an extra payload byte instead of the truncation flag, and a design that cleared the pending fill on abort would leave the following record unmarked. Traffic after the end-of-file command must produce nothing, which catches a parser that drops back to waiting for a length.

// File: rtl/tape_rec_pkg.sv
package tape_rec_pkg;
  typedef enum logic [1:0] {
    PS_IDLE     = 2'd0,
    PS_WAIT_LEN = 2'd1,
    PS_PAYLOAD  = 2'd2,
    PS_DONE     = 2'd3
  } prs_state_e;
endpackage

// File: rtl/trp_ctrl.sv
module trp_ctrl
  import tape_rec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic byte_valid,
  input  logic gap_strobe,
  input  logic cnt_last,
  input  logic eof_hit,
  output logic load_len,
  output logic take_byte,
  output logic abort
);
  prs_state_e state_q, state_d;

  // Gap has priority over a byte in the same cycle.
  assign load_len  = (state_q == PS_WAIT_LEN) && byte_valid && !gap_strobe;
  assign take_byte = (state_q == PS_PAYLOAD)  && byte_valid && !gap_strobe;
  assign abort     = (state_q == PS_PAYLOAD)  && gap_strobe;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE:     if (gap_strobe) state_d = PS_WAIT_LEN;
      PS_WAIT_LEN: if (load_len) state_d = PS_PAYLOAD;
      PS_PAYLOAD: begin
        if (abort) state_d = PS_WAIT_LEN;
        else if (take_byte && cnt_last) state_d = eof_hit ? PS_DONE : PS_WAIT_LEN;
      end
      PS_DONE:     state_d = PS_DONE;
      default:     state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_IDLE;
    else        state_q <= state_d;
  end

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_DONE) |=> (state_q == PS_DONE));
endmodule

// File: rtl/trp_counter.sv
module trp_counter #(
  parameter int DATA_W  = 8,
  parameter int LEN_CMD = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_len,
  input  logic              take_byte,
  input  logic [DATA_W-1:0] len_byte,
  output logic [DATA_W:0]   idx,
  output logic              is_first,
  output logic              is_last,
  output logic              is_cmd
);
  localparam int CNT_W = DATA_W + 1;
  localparam logic [CNT_W-1:0] FULL_LEN = CNT_W'(1) << DATA_W;

  logic [CNT_W-1:0] rem_q, rem_d, idx_q, idx_d;
  logic             cmd_q, cmd_d;

  always_comb begin
    rem_d = rem_q;
    idx_d = idx_q;
    cmd_d = cmd_q;
    if (load_len) begin
      rem_d = (len_byte == '0) ? FULL_LEN : {1'b0, len_byte};
      idx_d = '0;
      cmd_d = (len_byte == DATA_W'(LEN_CMD));
    end else if (take_byte) begin
      rem_d = rem_q - CNT_W'(1);
      idx_d = idx_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      idx_q <= '0;
      cmd_q <= 1'b0;
    end else if (load_len || take_byte) begin
      rem_q <= rem_d;
      idx_q <= idx_d;
      cmd_q <= cmd_d;
    end
  end

  assign idx      = idx_q;
  assign is_first = (idx_q == '0);
  assign is_last  = (rem_q == CNT_W'(1));
  assign is_cmd   = cmd_q;

  p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= FULL_LEN);
  p_take_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_byte |-> (rem_q != '0));
endmodule

// File: rtl/trp_cmd_track.sv
module trp_cmd_track #(
  parameter int              DATA_W    = 8,
  parameter logic [DATA_W-1:0] CODE_FILL = 8'hFE,
  parameter logic [DATA_W-1:0] CODE_EOF  = 8'hFD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_len,
  input  logic              take_byte,
  input  logic              is_last,
  input  logic              is_cmd,
  input  logic [DATA_W-1:0] byte_data,
  output logic              cmd_hit,
  output logic              fill_hit,
  output logic              eof_hit,
  output logic              fill_pending,
  output logic              rec_fill
);
  logic pend_q, pend_d, recf_q, recf_d;
  logic rec_done;

  assign rec_done = take_byte && is_last;
  assign cmd_hit  = rec_done && is_cmd;
  assign fill_hit = cmd_hit && (byte_data == CODE_FILL);
  assign eof_hit  = cmd_hit && (byte_data == CODE_EOF);

  always_comb begin
    pend_d = pend_q;
    recf_d = recf_q;
    if (load_len) recf_d = pend_q;
    if (rec_done && recf_q) pend_d = 1'b0;
    if (fill_hit) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      recf_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (load_len) recf_q <= recf_d;
    end
  end

  assign fill_pending = pend_q;
  assign rec_fill     = recf_q;

  p_fill_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> $past(rec_done && recf_q));
  p_fill_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(fill_hit));
endmodule

// File: rtl/tape_rec_parser.sv
module tape_rec_parser #(
  parameter int                DATA_W    = 8,
  parameter int                LEN_CMD   = 5,
  parameter logic [DATA_W-1:0] CODE_FILL = 8'hFE,
  parameter logic [DATA_W-1:0] CODE_EOF  = 8'hFD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              gap_strobe,
  output logic              pay_valid,
  output logic [DATA_W-1:0] pay_data,
  output logic [DATA_W:0]   pay_index,
  output logic              pay_first,
  output logic              pay_last,
  output logic              pay_fill,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_code,
  output logic              fill_cmd,
  output logic              trunc_err,
  output logic              fill_pending,
  output logic              eof
);
  localparam int CNT_W = DATA_W + 1;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  logic load_len, take_byte, abort;
  logic cnt_first, cnt_last, cnt_cmd;
  logic [CNT_W-1:0] cnt_idx;
  logic cmd_hit, fill_hit, eof_hit, rec_fill;

  trp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_q),
    .byte_valid(byte_valid), .gap_strobe(gap_strobe),
    .cnt_last(cnt_last), .eof_hit(eof_hit),
    .load_len(load_len), .take_byte(take_byte), .abort(abort)
  );

  trp_counter #(.DATA_W(DATA_W), .LEN_CMD(LEN_CMD)) u_cnt (
    .clk(clk), .rst_n(rst_q),
    .load_len(load_len), .take_byte(take_byte), .len_byte(byte_data),
    .idx(cnt_idx), .is_first(cnt_first), .is_last(cnt_last), .is_cmd(cnt_cmd)
  );

  trp_cmd_track #(.DATA_W(DATA_W), .CODE_FILL(CODE_FILL), .CODE_EOF(CODE_EOF)) u_cmd (
    .clk(clk), .rst_n(rst_q),
    .load_len(load_len), .take_byte(take_byte),
    .is_last(cnt_last), .is_cmd(cnt_cmd), .byte_data(byte_data),
    .cmd_hit(cmd_hit), .fill_hit(fill_hit), .eof_hit(eof_hit),
    .fill_pending(fill_pending), .rec_fill(rec_fill)
  );

  // Per-cycle strobes.
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      pay_valid <= 1'b0;
      pay_first <= 1'b0;
      pay_last  <= 1'b0;
      pay_fill  <= 1'b0;
      cmd_valid <= 1'b0;
      fill_cmd  <= 1'b0;
      trunc_err <= 1'b0;
      eof       <= 1'b0;
    end else begin
      pay_valid <= take_byte;
      pay_first <= take_byte && cnt_first;
      pay_last  <= take_byte && cnt_last;
      pay_fill  <= take_byte && rec_fill;
      cmd_valid <= cmd_hit;
      fill_cmd  <= fill_hit;
      trunc_err <= abort;
      eof       <= eof || eof_hit;
    end
  end

  // Data registers, loaded only when enabled.
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      pay_data  <= '0;
      pay_index <= '0;
    end else if (take_byte) begin
      pay_data  <= byte_data;
      pay_index <= cnt_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)       cmd_code <= '0;
    else if (cmd_hit) cmd_code <= byte_data;
  end

  p_first_idx_r4: assert property (@(posedge clk) disable iff (!rst_q)
    pay_first |-> (pay_valid && pay_index == '0));
  p_cmd_on_last_r5: assert property (@(posedge clk) disable iff (!rst_q)
    cmd_valid |-> (pay_valid && pay_last));
  p_quiet_after_eof_r7: assert property (@(posedge clk) disable iff (!rst_q)
    $past(eof) |-> (!pay_valid && !trunc_err && eof));
  p_trunc_excl_r8: assert property (@(posedge clk) disable iff (!rst_q)
    trunc_err |-> !pay_valid);
endmodule

// File: tb/tape_rec_parser_tb.sv
`timescale 1ns/1ps
module tape_rec_parser_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, byte_valid, gap_strobe;
  logic [7:0] byte_data;
  logic       pay_valid, pay_first, pay_last, pay_fill, cmd_valid, fill_cmd;
  logic       trunc_err, fill_pending, eof;
  logic [7:0] pay_data, cmd_code;
  logic [8:0] pay_index;

  tape_rec_parser u_dut (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .gap_strobe(gap_strobe), .pay_valid(pay_valid), .pay_data(pay_data),
    .pay_index(pay_index), .pay_first(pay_first), .pay_last(pay_last),
    .pay_fill(pay_fill), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .fill_cmd(fill_cmd), .trunc_err(trunc_err), .fill_pending(fill_pending), .eof(eof)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [32:0] exp_q[$];
  string       tag_q[$];

  // Bench model of the requirements.
  bit m_started, m_fill, m_done;

  function automatic logic [32:0] mk(logic tr, logic [7:0] d, logic [8:0] ix,
      logic f, logic l, logic fl, logic cv, logic fc, logic [7:0] cc, logic ef, logic fp);
    return {tr, d, ix, f, l, fl, cv, fc, cc, ef, fp};
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard whenever the design presents an item.
  always @(negedge clk) begin
    if (rst_n && !finished && (pay_valid || trunc_err)) begin
      logic [32:0] act;
      act = mk(trunc_err, pay_valid ? pay_data : 8'h0, pay_valid ? pay_index : 9'h0,
               pay_valid & pay_first, pay_valid & pay_last, pay_valid & pay_fill,
               cmd_valid, fill_cmd, cmd_valid ? cmd_code : 8'h0, eof, fill_pending);
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected output actual=%0h expected=none", act);
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          errors++;
          $display("FAIL %s item actual=%0h expected=%0h", t, act, e);
        end
      end
    end
  end

  task automatic cyc(logic v, logic [7:0] b, logic g);
    byte_valid = v; byte_data = b; gap_strobe = g;
    @(negedge clk);
    byte_valid = 1'b0; byte_data = 8'h0; gap_strobe = 1'b0;
  endtask

  // tmode: 1 = gap alone cuts the record, 2 = gap together with a byte.
  task automatic send_record(logic [7:0] lenb, int nsend, logic [7:0] seed,
      logic [7:0] ovr, bit use_ovr, int spacing, int tmode, string tag);
    int plen;
    bit rf;
    plen = (lenb == 8'h0) ? 256 : int'(lenb);
    cyc(0, 8'h0, 1);
    if (!m_done) m_started = 1;
    cyc(1, lenb, 0);
    rf = m_fill;
    for (int i = 0; i < nsend; i++) begin
      logic [7:0] d;
      bit last, cv, fc, ef;
      d    = (use_ovr && i == plen - 1) ? ovr : 8'(seed + i);
      last = (i == plen - 1);
      cv   = last && (plen == 5);
      fc   = cv && (d == 8'hFE);
      ef   = cv && (d == 8'hFD);
      if (!m_done) begin
        if (last && rf) m_fill = 0;
        if (fc) m_fill = 1;
        exp_q.push_back(mk(0, d, 9'(i), i == 0, last, rf, cv, fc, cv ? d : 8'h0, ef, m_fill));
        tag_q.push_back(tag);
        if (ef) m_done = 1;
      end
      cyc(1, d, 0);
      repeat (spacing) cyc(0, 8'h0, 0);
    end
    if (nsend < plen) begin
      if (!m_done) begin
        exp_q.push_back(mk(1, 8'h0, 9'h0, 0, 0, 0, 0, 0, 8'h0, 0, m_fill));
        tag_q.push_back("R8");
      end
      if (tmode == 2) cyc(1, 8'hAA, 1);
      else            cyc(0, 8'h0, 1);
    end
  endtask

  task automatic drain(string tag);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, tag, "pending items", exp_q.size(), 0);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      finished = 1;
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; byte_valid = 1'b0; byte_data = 8'h0; gap_strobe = 1'b0;
    m_started = 0; m_fill = 0; m_done = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({pay_valid, pay_first, pay_last, pay_fill, cmd_valid, fill_cmd, trunc_err, fill_pending, eof} == 9'h0,
        "R1", "reset outputs",
        {pay_valid, pay_first, pay_last, pay_fill, cmd_valid, fill_cmd, trunc_err, fill_pending, eof}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: bytes before the first gap are ignored
    for (int i = 0; i < 4; i++) begin
      cyc(1, 8'h03, 0);
      chk(!pay_valid && !trunc_err, "R1", "output before first gap", pay_valid, 0);
    end

    // R9: extra gaps while waiting for a length
    cyc(0, 8'h0, 1);
    cyc(0, 8'h0, 1);
    chk(!pay_valid && !trunc_err, "R9", "gap while waiting", trunc_err, 0);
    send_record(8'd3, 3, 8'h10, 8'h0, 0, 0, 0, "R2");
    send_record(8'd1, 1, 8'h77, 8'h0, 0, 0, 0, "R4");
    send_record(8'd6, 6, 8'h20, 8'h0, 0, 2, 0, "R2");
    send_record(8'd5, 5, 8'h30, 8'h42, 1, 0, 0, "R10");
    drain("R10");
    chk(!fill_pending && !eof, "R10", "other code no fill/eof", {fill_pending, eof}, 0);

    // R6: fill command then fill record
    send_record(8'd5, 5, 8'h40, 8'hFE, 1, 0, 0, "R6");
    drain("R6");
    chk(fill_pending, "R6", "pending after fill cmd", fill_pending, 1);
    send_record(8'd4, 4, 8'h50, 8'h0, 0, 1, 0, "R6");
    drain("R6");
    chk(!fill_pending, "R6", "pending cleared", fill_pending, 0);
    send_record(8'd2, 2, 8'h60, 8'h0, 0, 0, 0, "R6");

    // R8: truncation keeps the pending fill
    send_record(8'd5, 5, 8'h70, 8'hFE, 1, 0, 0, "R6");
    send_record(8'd8, 3, 8'h80, 8'h0, 0, 0, 1, "R8");
    drain("R8");
    chk(fill_pending, "R8", "pending kept on abort", fill_pending, 1);
    send_record(8'd3, 3, 8'h90, 8'h0, 0, 0, 0, "R8");
    // R8: gap and byte together, gap wins
    send_record(8'd9, 4, 8'hA0, 8'h0, 0, 0, 2, "R8");
    send_record(8'd2, 2, 8'hB0, 8'h0, 0, 0, 0, "R8");

    // R3: length zero means 256 bytes
    send_record(8'd0, 256, 8'h00, 8'h0, 0, 0, 0, "R3");
    drain("R3");

    // R7: end of file then traffic is ignored
    send_record(8'd5, 5, 8'hC0, 8'hFD, 1, 0, 0, "R7");
    drain("R7");
    chk(eof, "R7", "eof set", eof, 1);
    send_record(8'd3, 3, 8'hD0, 8'h0, 0, 0, 0, "R7");
    send_record(8'd4, 2, 8'hE0, 8'h0, 0, 0, 1, "R7");
    drain("R7");
    chk(eof && !pay_valid, "R7", "eof held", eof, 1);

    // R1: reset again clears end of file
    rst_n = 1'b0;
    #1;
    chk(!eof && !fill_pending, "R1", "reset clears eof", eof, 0);
    m_started = 0; m_fill = 0; m_done = 0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send_record(8'd2, 2, 8'hF0, 8'h0, 0, 0, 0, "R2");
    drain("R2");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule